// File: doc/BRIEF.md
# Random Source Output and Alarm Register Block

This block is the software-facing register file that sits between a random-number source and a processor bus. It captures a group of 32-bit random words from the source into an output latch and holds them until software has read them. Software then writes a one to the ready flag, which frees the latch for the next group. Alongside the latch it keeps a status word of sticky failure causes reported by the health tests. It raises one interrupt line for the causes that software has enabled.

The block also guards a bank of free-running oscillators. The first alarm from a running oscillator arms it. A second alarm on an armed oscillator stops that oscillator, records the stop, and flags a shutdown in the status word. Writing ones to the oscillator enable register restarts the stopped oscillators and clears their records. Configuration fields (refill cycle limits, alarm threshold, detune) are plain storage that drive the source through output pins. The bus is a simple single-cycle write strobe with a combinational read path.

Top module: `rng_alarm_regs`

## Requirements
- R1: After reset every register reads zero, except revision at 0x7C and options at 0x78. `irq`, `src_take`, `rng_enable` and all oscillator enables are low.
- R2: When the global enable is set, ready is clear and `src_valid` is high, `src_take` is high. At that clock edge word k (offset 4k) loads `src_data[32k+31:32k]`, and ready (status bit 0 at 0x10) is set on the same edge.
- R3: While ready is set, or while the global enable is clear, the output words do not change and `src_take` stays low.
- R4: Writing 0x10 with bit 0 set clears ready. A waiting source is then accepted on the following cycle.
- R5: `health_fail[j]` sets status bit j+2 (bit 2 stuck, 3 noise, 4 run, 5 long run, 6 poker, 7 monobit). Writing a one to a status bit clears it. A set and a clear in the same cycle leave the bit set.
- R6: `irq` is high exactly when the global enable (control bit 10 at 0x14) is set and some status bit i in 1..7 is set together with control bit i.
- R7: Control (bit 10 and bits 7:1), config at 0x18 (min refill bits 7:0, max refill bits 31:16), threshold at 0x1C (bits 7:0) and detune at 0x24 read back as written. Each also drives its output pin.
- R8: An alarm on a running oscillator i that is not armed sets bit i of 0x28. An alarm on an armed running oscillator clears its enable bit (0x20) and its armed bit, sets bit i of 0x2C, and sets status bit 1.
- R9: Writing 0x20 loads the enables and clears the stop and armed bits of every oscillator written with a one. An alarm on a disabled oscillator has no effect. Writing 0x28 or 0x2C clears the bits written as zero. No oscillator is both stopped and enabled.
- R10: 0x7C reads {4'h0, major, minor, patch, 16'h0} and 0x78 reads NUM_WORDS in bits 15:8 and NUM_FRO in bits 7:0. Unmapped offsets read zero, and writes to them or to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_valid | input | 1 | Source has a group of words |
| src_data | input | 32*NUM_WORDS | Group of random words, word 0 in the low bits |
| src_take | output | 1 | Group accepted at this edge |
| health_fail | input | 6 | Health-test failure pulses |
| alarm_evt | input | NUM_FRO | Per-oscillator alarm pulses |
| rng_enable | output | 1 | Global enable |
| min_refill | output | 8 | Minimum refill cycle count |
| max_refill | output | 16 | Maximum refill cycle count |
| alarm_thresh | output | 8 | Alarm threshold |
| fro_detune | output | NUM_FRO | Per-oscillator detune |
| fro_en | output | NUM_FRO | Per-oscillator run enable |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with four oscillators, so a single random write covers the whole enable, armed and stop bank. It sets nonzero revision fields so that the constant registers differ from their reset values. With four oscillators, random alarm pulses often land on armed and disabled oscillators, and they often coincide with enable writes and mask writes. This reaches the ordering cases between a trip and a restart in the same cycle. The four-word latch keeps the ready handshake and the interaction between a write to 0x10 and a pending source on the same short timescale as the status clears.

// File: rtl/rng_alarm_regs_pkg.sv
`timescale 1ns/1ps
package rng_alarm_regs_pkg;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_THRESH = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_FROEN  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_DETUNE = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_ARMED  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_STOP   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_OPTS   = 8'h78;
  localparam logic [ADDR_W-1:0] OFF_REV    = 8'h7C;

  localparam int BIT_READY  = 0;
  localparam int BIT_SHUT   = 1;
  localparam int BIT_GLOBAL = 10;
  localparam int NUM_HEALTH = 6;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_STAT, SEL_CTRL, SEL_CFG, SEL_THRESH,
    SEL_FROEN, SEL_DETUNE, SEL_ARMED, SEL_STOP, SEL_OPTS, SEL_REV
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a, input int num_words);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00 && int'(a) < 4 * num_words) s = SEL_DATA;
    else begin
      case (a)
        OFF_STAT:   s = SEL_STAT;
        OFF_CTRL:   s = SEL_CTRL;
        OFF_CFG:    s = SEL_CFG;
        OFF_THRESH: s = SEL_THRESH;
        OFF_FROEN:  s = SEL_FROEN;
        OFF_DETUNE: s = SEL_DETUNE;
        OFF_ARMED:  s = SEL_ARMED;
        OFF_STOP:   s = SEL_STOP;
        OFF_OPTS:   s = SEL_OPTS;
        OFF_REV:    s = SEL_REV;
        default:    s = SEL_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/rng_out_latch.sv
`timescale 1ns/1ps
module rng_out_latch #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        src_valid,
  input  logic [NUM_WORDS*WORD_W-1:0] src_data,
  input  logic                        release_req,
  output logic                        take,
  output logic                        ready,
  output logic [NUM_WORDS*WORD_W-1:0] words
);
  logic ready_q, ready_d;

  always_comb begin
    take    = enable & src_valid & ~ready_q;
    ready_d = ready_q;
    if (take)             ready_d = 1'b1;
    else if (release_req) ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (take) word_q <= src_data[k*WORD_W +: WORD_W];
    end
    assign words[k*WORD_W +: WORD_W] = word_q;
  end

  assign ready = ready_q;
endmodule

// File: rtl/rng_cause_status.sv
`timescale 1ns/1ps
module rng_cause_status #(
  parameter int NUM_CAUSE = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] set_pulse,
  input  logic [NUM_CAUSE-1:0] clr_mask,
  output logic [NUM_CAUSE-1:0] pending
);
  logic [NUM_CAUSE-1:0] stat_q, stat_d;

  always_comb stat_d = (stat_q & ~clr_mask) | set_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign pending = stat_q;
endmodule

// File: rtl/rng_fro_guard.sv
`timescale 1ns/1ps
module rng_fro_guard #(
  parameter int NUM_FRO = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FRO-1:0] alarm_evt,
  input  logic               wr_enable,
  input  logic               wr_armed,
  input  logic               wr_stop,
  input  logic [NUM_FRO-1:0] wdata,
  output logic [NUM_FRO-1:0] fro_en,
  output logic [NUM_FRO-1:0] armed,
  output logic [NUM_FRO-1:0] stopped,
  output logic               shutdown
);
  logic [NUM_FRO-1:0] en_q, en_d, arm_q, arm_d, stp_q, stp_d;
  logic [NUM_FRO-1:0] live, trip, first;

  always_comb begin
    live  = alarm_evt & en_q;
    trip  = live & arm_q;
    first = live & ~arm_q;
    en_d  = en_q;
    arm_d = arm_q;
    stp_d = stp_q;
    if (wr_enable) begin
      en_d  = wdata;
      arm_d = arm_d & ~wdata;
      stp_d = stp_d & ~wdata;
    end
    if (wr_armed) arm_d = arm_d & wdata;
    if (wr_stop)  stp_d = stp_d & wdata;
    arm_d = (arm_d | first) & ~trip;
    en_d  = en_d & ~trip;
    stp_d = stp_d | trip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      arm_q <= '0;
      stp_q <= '0;
    end else begin
      en_q  <= en_d;
      arm_q <= arm_d;
      stp_q <= stp_d;
    end
  end

  assign fro_en   = en_q;
  assign armed    = arm_q;
  assign stopped  = stp_q;
  assign shutdown = |trip;
endmodule

// File: rtl/rng_alarm_regs.sv
`timescale 1ns/1ps
module rng_alarm_regs
  import rng_alarm_regs_pkg::*;
#(
  parameter int         NUM_WORDS = 4,
  parameter int         NUM_FRO   = 8,
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd0,
  parameter logic [3:0] REV_PATCH = 4'd0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [7:0]                  reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic                        src_valid,
  input  logic [NUM_WORDS*32-1:0]     src_data,
  output logic                        src_take,
  input  logic [5:0]                  health_fail,
  input  logic [NUM_FRO-1:0]          alarm_evt,
  output logic                        rng_enable,
  output logic [7:0]                  min_refill,
  output logic [15:0]                 max_refill,
  output logic [7:0]                  alarm_thresh,
  output logic [NUM_FRO-1:0]          fro_detune,
  output logic [NUM_FRO-1:0]          fro_en,
  output logic                        irq
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [31:0] REV_WORD  = {4'h0, REV_MAJOR, REV_MINOR, REV_PATCH, 16'h0};
  localparam logic [31:0] OPTS_WORD = {16'h0, 8'(NUM_WORDS), 8'(NUM_FRO)};

  reg_sel_e sel;
  logic wr_stat, wr_ctrl, wr_cfg, wr_thr, wr_froen, wr_det, wr_arm, wr_stp;

  always_comb begin
    sel      = decode_addr(reg_addr, NUM_WORDS);
    wr_stat  = reg_wr && sel == SEL_STAT;
    wr_ctrl  = reg_wr && sel == SEL_CTRL;
    wr_cfg   = reg_wr && sel == SEL_CFG;
    wr_thr   = reg_wr && sel == SEL_THRESH;
    wr_froen = reg_wr && sel == SEL_FROEN;
    wr_det   = reg_wr && sel == SEL_DETUNE;
    wr_arm   = reg_wr && sel == SEL_ARMED;
    wr_stp   = reg_wr && sel == SEL_STOP;
  end

  // Control and configuration storage
  logic               ctrl_en_q;
  logic [7:1]         ctrl_ie_q;
  logic [7:0]         min_q, thr_q;
  logic [15:0]        max_q;
  logic [NUM_FRO-1:0] det_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q <= 1'b0;
      ctrl_ie_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_en_q <= reg_wdata[BIT_GLOBAL];
      ctrl_ie_q <= reg_wdata[7:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0;
      max_q <= '0;
    end else if (wr_cfg) begin
      min_q <= reg_wdata[7:0];
      max_q <= reg_wdata[31:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (wr_thr) thr_q <= reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      det_q <= '0;
    else if (wr_det) det_q <= reg_wdata[NUM_FRO-1:0];
  end

  // Output latch
  logic                    ready;
  logic [NUM_WORDS*32-1:0] data_q;
  logic                    release_req;

  assign release_req = wr_stat & reg_wdata[BIT_READY];

  rng_out_latch #(.NUM_WORDS(NUM_WORDS), .WORD_W(32)) u_latch (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_en_q), .src_valid(src_valid),
    .src_data(src_data), .release_req(release_req), .take(src_take),
    .ready(ready), .words(data_q)
  );

  // Oscillator guard
  logic [NUM_FRO-1:0] armed_q, stop_q;
  logic               shut_evt;

  rng_fro_guard #(.NUM_FRO(NUM_FRO)) u_guard (
    .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .wr_enable(wr_froen),
    .wr_armed(wr_arm), .wr_stop(wr_stp), .wdata(reg_wdata[NUM_FRO-1:0]),
    .fro_en(fro_en), .armed(armed_q), .stopped(stop_q), .shutdown(shut_evt)
  );

  // Cause status, bits 7:1
  logic [7:1] stat_q, stat_set, stat_clr;

  always_comb begin
    stat_set = {health_fail, shut_evt};
    stat_clr = wr_stat ? reg_wdata[7:1] : 7'h0;
  end

  rng_cause_status #(.NUM_CAUSE(7)) u_status (
    .clk(clk), .rst_n(rst_n), .set_pulse(stat_set), .clr_mask(stat_clr),
    .pending(stat_q)
  );

  // Read path
  logic [IDX_W-1:0] widx;
  assign widx = reg_addr[IDX_W+1:2];

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_DATA:   reg_rdata = data_q[32*widx +: 32];
      SEL_STAT:   reg_rdata = {24'h0, stat_q, ready};
      SEL_CTRL:   reg_rdata = {21'h0, ctrl_en_q, 2'b00, ctrl_ie_q, 1'b0};
      SEL_CFG:    reg_rdata = {max_q, 8'h0, min_q};
      SEL_THRESH: reg_rdata = {24'h0, thr_q};
      SEL_FROEN:  reg_rdata = 32'(fro_en);
      SEL_DETUNE: reg_rdata = 32'(det_q);
      SEL_ARMED:  reg_rdata = 32'(armed_q);
      SEL_STOP:   reg_rdata = 32'(stop_q);
      SEL_OPTS:   reg_rdata = OPTS_WORD;
      SEL_REV:    reg_rdata = REV_WORD;
      default:    reg_rdata = '0;
    endcase
  end

  assign irq          = ctrl_en_q & |(stat_q & ctrl_ie_q);
  assign rng_enable   = ctrl_en_q;
  assign min_refill   = min_q;
  assign max_refill   = max_q;
  assign alarm_thresh = thr_q;
  assign fro_detune   = det_q;
endmodule

// File: rtl/rng_alarm_regs_chk.sv
`timescale 1ns/1ps
module rng_alarm_regs_chk #(
  parameter int NUM_WORDS = 4,
  parameter int NUM_FRO   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic [7:0]              reg_addr,
  input logic [31:0]             reg_wdata,
  input logic                    src_take,
  input logic                    ready,
  input logic [NUM_WORDS*32-1:0] data_q,
  input logic                    ctrl_en_q,
  input logic                    irq,
  input logic [NUM_FRO-1:0]      fro_en,
  input logic [NUM_FRO-1:0]      armed_q,
  input logic [NUM_FRO-1:0]      stop_q,
  input logic [NUM_FRO-1:0]      alarm_evt,
  input logic [7:1]              stat_q
);
  logic rel;
  assign rel = reg_wr && reg_addr == 8'h10 && reg_wdata[0];

  assert_take_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |-> (ctrl_en_q && !ready));

  assert_take_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |=> ready);

  assert_hold_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> $stable(data_q));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rel) |=> !ready);

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en_q |-> !irq);

  assert_trip_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(alarm_evt & armed_q & fro_en)) |=> stat_q[1]);

  assert_stop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q & fro_en) == '0);
endmodule

bind rng_alarm_regs rng_alarm_regs_chk #(.NUM_WORDS(NUM_WORDS), .NUM_FRO(NUM_FRO)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .src_take(src_take), .ready(ready), .data_q(data_q),
  .ctrl_en_q(ctrl_en_q), .irq(irq), .fro_en(fro_en), .armed_q(armed_q),
  .stop_q(stop_q), .alarm_evt(alarm_evt), .stat_q(stat_q)
);

// File: tb/tb_rng_alarm_regs.sv
`timescale 1ns/1ps
module tb_rng_alarm_regs;
  localparam int NW = 4;
  localparam int NF = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          src_valid, src_take;
  logic [NW*32-1:0] src_data;
  logic [5:0]    health_fail;
  logic [NF-1:0] alarm_evt, fro_detune, fro_en;
  logic          rng_enable, irq;
  logic [7:0]    min_refill, alarm_thresh;
  logic [15:0]   max_refill;

  rng_alarm_regs #(.NUM_WORDS(NW), .NUM_FRO(NF), .REV_MAJOR(4'd2),
                   .REV_MINOR(4'd1), .REV_PATCH(4'd3)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
    .src_data(src_data), .src_take(src_take), .health_fail(health_fail),
    .alarm_evt(alarm_evt), .rng_enable(rng_enable), .min_refill(min_refill),
    .max_refill(max_refill), .alarm_thresh(alarm_thresh),
    .fro_detune(fro_detune), .fro_en(fro_en), .irq(irq)
  );

  // Reference model state
  logic [31:0]   m_w [NW];
  bit            m_rdy, m_en;
  logic [7:1]    m_st, m_ie;
  logic [7:0]    m_min, m_thr;
  logic [15:0]   m_max;
  logic [NF-1:0] m_det, m_fen, m_arm, m_stp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic model_reset();
    for (int k = 0; k < NW; k++) m_w[k] = '0;
    m_rdy = 0; m_en = 0; m_st = '0; m_ie = '0; m_min = '0; m_thr = '0;
    m_max = '0; m_det = '0; m_fen = '0; m_arm = '0; m_stp = '0;
  endtask

  function automatic bit m_take();
    return m_en && src_valid && !m_rdy;
  endfunction

  function automatic bit m_irq();
    return m_en && ((m_st & m_ie) != 0);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] == 0 && a < 8'(4*NW)) return m_w[a[7:2]];
    case (a)
      8'h10: return {24'h0, m_st, m_rdy};
      8'h14: return {21'h0, m_en, 2'b00, m_ie, 1'b0};
      8'h18: return {m_max, 8'h0, m_min};
      8'h1C: return {24'h0, m_thr};
      8'h20: return 32'(m_fen);
      8'h24: return 32'(m_det);
      8'h28: return 32'(m_arm);
      8'h2C: return 32'(m_stp);
      8'h78: return 32'h0000_0404;
      8'h7C: return 32'h0213_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    bit tk, w;
    logic [7:0] a;
    logic [31:0] d;
    logic [NF-1:0] live, trip, fen_n, arm_n, stp_n;
    logic [7:1] st_n;
    tk = m_take(); w = reg_wr; a = reg_addr; d = reg_wdata;
    live = alarm_evt & m_fen;
    trip = live & m_arm;
    st_n = m_st;
    if (w && a == 8'h10) st_n = st_n & ~d[7:1];
    st_n[1] = st_n[1] | (trip != 0);
    st_n[7:2] = st_n[7:2] | health_fail;
    fen_n = m_fen; arm_n = m_arm; stp_n = m_stp;
    if (w && a == 8'h20) begin
      fen_n = d[NF-1:0]; arm_n = arm_n & ~d[NF-1:0]; stp_n = stp_n & ~d[NF-1:0];
    end
    if (w && a == 8'h28) arm_n = arm_n & d[NF-1:0];
    if (w && a == 8'h2C) stp_n = stp_n & d[NF-1:0];
    arm_n = (arm_n | (live & ~m_arm)) & ~trip;
    fen_n = fen_n & ~trip;
    stp_n = stp_n | trip;
    if (tk) begin
      for (int k = 0; k < NW; k++) m_w[k] = src_data[32*k +: 32];
      m_rdy = 1;
    end else if (w && a == 8'h10 && d[0]) m_rdy = 0;
    if (w && a == 8'h14) begin m_en = d[10]; m_ie = d[7:1]; end
    if (w && a == 8'h18) begin m_min = d[7:0]; m_max = d[31:16]; end
    if (w && a == 8'h1C) m_thr = d[7:0];
    if (w && a == 8'h24) m_det = d[NF-1:0];
    m_st = st_n; m_fen = fen_n; m_arm = arm_n; m_stp = stp_n;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: compare outputs, advance model at the edge, clear pulses
  task automatic tick(input string req);
    #1;
    chk(req, "rdata", reg_rdata, m_read(reg_addr));
    chk(req, "irq", 32'(irq), 32'(m_irq()));
    chk(req, "src_take", 32'(src_take), 32'(m_take()));
    chk(req, "fro_en", 32'(fro_en), 32'(m_fen));
    chk(req, "cfg_out", {7'h0, rng_enable, max_refill, min_refill},
        {7'h0, m_en, m_max, m_min});
    chk(req, "thr_det", {20'h0, fro_detune, alarm_thresh}, {20'h0, m_det, m_thr});
    @(posedge clk);
    model_step();
    @(negedge clk);
    reg_wr = 0; health_fail = '0; alarm_evt = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick(req);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    reg_addr = a;
    tick(req);
  endtask

  task automatic rd_all(input string req);
    logic [7:0] offs [14] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                              8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h78, 8'h7C};
    for (int i = 0; i < 14; i++) rd(offs[i], req);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0; src_valid = 0;
    src_data = '0; health_fail = '0; alarm_evt = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd_all("R1");

    // R3: no load while disabled
    src_valid = 1; src_data = {32'hD4D4D4D4, 32'hC3C3C3C3, 32'hB2B2B2B2, 32'hA1A1A1A1};
    rd(8'h00, "R3"); rd(8'h10, "R3");
    src_valid = 0;

    // R7: configuration readback
    wr(8'h18, 32'hBEEF_0055, "R7"); rd(8'h18, "R7");
    wr(8'h1C, 32'hFFFF_FFAB, "R7"); rd(8'h1C, "R7");
    wr(8'h24, 32'h0000_0005, "R7"); rd(8'h24, "R7");
    wr(8'h14, 32'hFFFF_FFFF, "R7"); rd(8'h14, "R7");

    // R2: load a group
    src_valid = 1;
    rd(8'h10, "R2");
    src_valid = 0;
    for (int k = 0; k < NW; k++) rd(8'(4*k), "R2");
    rd(8'h10, "R2");

    // R3: hold while ready
    src_valid = 1; src_data = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    rd(8'h00, "R3"); rd(8'h0C, "R3"); rd(8'h04, "R3");

    // R4: release then reload
    wr(8'h10, 32'h0000_0001, "R4");
    rd(8'h10, "R4");
    src_valid = 0;
    for (int k = 0; k < NW; k++) rd(8'(4*k), "R4");

    // R5: each health cause
    for (int j = 0; j < 6; j++) begin
      health_fail = 6'(1 << j);
      rd(8'h10, "R5");
      rd(8'h10, "R5");
    end
    wr(8'h10, 32'h0000_00F0, "R5"); rd(8'h10, "R5");
    health_fail = 6'b000100;
    wr(8'h10, 32'h0000_0010, "R5"); rd(8'h10, "R5");

    // R6: interrupt gating
    wr(8'h14, 32'h0000_0402, "R6"); rd(8'h10, "R6");
    wr(8'h14, 32'h0000_0010, "R6"); rd(8'h10, "R6");
    wr(8'h14, 32'h0000_0410, "R6"); rd(8'h10, "R6");
    wr(8'h10, 32'h0000_00FE, "R6"); rd(8'h10, "R6");

    // R8: arm then trip oscillator 0
    wr(8'h20, 32'h0000_000F, "R8");
    alarm_evt = 4'b0001; rd(8'h28, "R8");
    rd(8'h28, "R8");
    alarm_evt = 4'b0001; rd(8'h2C, "R8");
    rd(8'h2C, "R8"); rd(8'h20, "R8"); rd(8'h10, "R8");

    // R9: alarm on stopped oscillator ignored, restart, mask clear
    alarm_evt = 4'b0001; rd(8'h28, "R9");
    rd(8'h28, "R9"); rd(8'h2C, "R9");
    wr(8'h20, 32'h0000_000F, "R9"); rd(8'h2C, "R9"); rd(8'h20, "R9");
    alarm_evt = 4'b0110; rd(8'h28, "R9");
    wr(8'h28, 32'h0000_0004, "R9"); rd(8'h28, "R9");
    alarm_evt = 4'b0100; wr(8'h20, 32'h0000_0004, "R9"); rd(8'h2C, "R9");
    rd(8'h20, "R9");

    // R10: unmapped and read-only writes ignored
    wr(8'h40, 32'hFFFF_FFFF, "R10");
    wr(8'h7C, 32'hFFFF_FFFF, "R10");
    wr(8'h78, 32'hFFFF_FFFF, "R10");
    wr(8'h02, 32'hFFFF_FFFF, "R10");
    rd(8'h40, "R10"); rd(8'h13, "R10");
    rd_all("R10");

    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0] offs [15] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h78, 8'h7C, 8'h50};
      reg_addr  = offs[$urandom % 15];
      reg_wr    = ($urandom % 4) == 0;
      reg_wdata = $urandom;
      if (reg_addr == 8'h14 && reg_wr) reg_wdata[10] = ($urandom % 4) != 0;
      src_valid = $urandom % 2;
      src_data  = {$urandom, $urandom, $urandom, $urandom};
      health_fail = (($urandom % 8) == 0) ? 6'($urandom) : 6'h0;
      alarm_evt   = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      tick("R2/R5/R6/R8/R9");
    end

    summary();
  end
endmodule